// File: doc/BRIEF.md
# Register-Driven Serial Flash Pin Port

This block is a small memory-mapped slave that hands a processor direct control of the pins of a serial configuration flash. There is no shift engine inside. Software produces every edge of the serial clock and every data bit by writing to word registers. The block registers the input data line, and software reads that registered value back through the bus.

Two write addresses each set the serial clock level and the outgoing data bit in a single access. The low-clock word drives the clock low and the high-clock word drives it high. Each address also loads the outgoing data bit from bit 0 of the written word. To send one bit in SPI mode 0, software writes the same value to the low-clock word, then to the high-clock word, then to the low-clock word again. It then shifts the value right by one place, so bits go out least significant first. A control word holds the active-low chip select and a few other static pin levels. The bus takes a write every clock with no wait states, and reads return one clock later.

Top module: `spi_bitbang_port`

## Requirements
- R1: While reset is held and just after it is released, the serial clock is 0, the outgoing data bit is 0, the chip select is 1 (deselected), every auxiliary control pin is 1, and the read data bus is 0.
- R2: A write to word 0 (address 0) forces the serial clock to 0 and sets the outgoing data bit to bit 0 of the written data. Both pins take their new values at the clock edge that accepts the write. Bits 31..1 of the written data have no effect.
- R3: A write to word 1 (address 1) forces the serial clock to 1 and sets the outgoing data bit to bit 0 of the written data. Both pins take their new values at the clock edge that accepts the write.
- R4: The serial clock and the outgoing data bit hold their values across idle cycles, across reads, and across writes to addresses 2 and 3.
- R5: A write to word 2 (address 2) loads the control register from the low CTRL_W bits of the written data. Control bit 0 drives the chip select and bits CTRL_W-1..1 drive the auxiliary pins. Reading word 2 returns the control register zero-extended to 32 bits.
- R6: The incoming data line passes through two synchronizer flops and is captured only by a write to word 1. A value that changes one clock before such a write is not yet captured. Reading word 0 or word 1 returns the captured bit in bit 0, with bits 31..1 zero.
- R7: A write to word 3 (address 3) changes no pin and no register. A read of word 3 returns 0.
- R8: Read data appears on the read data bus one clock after the read is accepted. In any cycle that follows a clock with no read, the bus is 0. No access ever waits.
- R9: The three-write sequence per bit, shifted right between bits, produces a mode-0 stream. The outgoing data bit is stable at every rising edge of the serial clock, and bits go out least significant first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and logic clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Word address of the access |
| bus_wr | input | 1 | Write strobe, one access per clock |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data, valid one clock after bus_rd |
| spi_sclk | output | 1 | Serial clock to the flash |
| spi_mosi | output | 1 | Outgoing serial data bit |
| spi_miso | input | 1 | Incoming serial data bit, asynchronous |
| spi_cs_n | output | 1 | Active-low chip select (control bit 0) |
| spi_aux | output | CTRL_W-1 (2) | Static auxiliary pin levels (control bits above 0) |

## Verification
The bound checker watches the following every cycle:
- how the clock and data pins respond to low-clock and high-clock writes;
- that those pins hold when nothing addresses them;
- that the chip select follows control writes;
- that the pad word leaves the pins untouched;
- that the read bus is zero after idle cycles and carries only bit 0 on data-word reads.

Some behaviour only the bench scenarios can show. These include the reset levels and the two-flop delay before a changed input bit is captured. They also include the zero-extended control readback, and an entire byte exchanged least significant bit first against a modelled flash. In that byte exchange, the bench records the outgoing bit at each rising serial clock edge.

// File: rtl/spibb_pkg.sv
`timescale 1ns/1ps
package spibb_pkg;
  localparam int ADDR_W = 2;

  // Word offsets in the register window; the low/high split is what
  // lets one write set both the clock level and the data bit.
  typedef enum logic [ADDR_W-1:0] {
    REG_CLK_LO = 2'd0,
    REG_CLK_HI = 2'd1,
    REG_CTRL   = 2'd2,
    REG_PAD    = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/spibb_pin_drive.sv
`timescale 1ns/1ps
// Registered serial clock and outgoing data bit.
module spibb_pin_drive (
  input  logic clk,
  input  logic rst,
  input  logic load_lo,
  input  logic load_hi,
  input  logic bit_in,
  output logic sclk_q,
  output logic mosi_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b0;
      mosi_q <= 1'b0;
    end else if (load_lo) begin
      sclk_q <= 1'b0;
      mosi_q <= bit_in;
    end else if (load_hi) begin
      sclk_q <= 1'b1;
      mosi_q <= bit_in;
    end
  end
endmodule

// File: rtl/spibb_miso_capture.sv
`timescale 1ns/1ps
// Synchronizer chain for the incoming data line plus a capture flop
// that loads on the rising serial clock write.
module spibb_miso_capture #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic miso_pin,
  input  logic capture,
  output logic bit_q
);
  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= miso_pin;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[STAGES-2:0], miso_pin};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)          bit_q <= 1'b0;
    else if (capture) bit_q <= sync_q[STAGES-1];
  end
endmodule

// File: rtl/spibb_ctrl_reg.sv
`timescale 1ns/1ps
// Static pin control register; resets to all ones (everything inactive).
module spibb_ctrl_reg #(
  parameter int CTRL_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [CTRL_W-1:0] wval,
  output logic [CTRL_W-1:0] ctrl_q
);
  always_ff @(posedge clk) begin
    if (rst)     ctrl_q <= '1;
    else if (we) ctrl_q <= wval;
  end
endmodule

// File: rtl/spi_bitbang_port.sv
`timescale 1ns/1ps
module spi_bitbang_port #(
  parameter int DATA_W      = 32,
  parameter int CTRL_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [spibb_pkg::ADDR_W-1:0] bus_addr,
  input  logic                    bus_wr,
  input  logic [DATA_W-1:0]       bus_wdata,
  input  logic                    bus_rd,
  output logic [DATA_W-1:0]       bus_rdata,
  output logic                    spi_sclk,
  output logic                    spi_mosi,
  input  logic                    spi_miso,
  output logic                    spi_cs_n,
  output logic [CTRL_W-2:0]       spi_aux
);
  import spibb_pkg::*;

  localparam int PAD_W = DATA_W - CTRL_W;

  reg_sel_e          sel;
  logic              wr_lo, wr_hi, wr_ctrl;
  logic              rx_bit;
  logic [CTRL_W-1:0] ctrl;
  logic [DATA_W-1:0] rd_mux;

  assign sel     = reg_sel_e'(bus_addr);
  assign wr_lo   = bus_wr && (sel == REG_CLK_LO);
  assign wr_hi   = bus_wr && (sel == REG_CLK_HI);
  assign wr_ctrl = bus_wr && (sel == REG_CTRL);

  spibb_pin_drive u_pins (
    .clk     (clk),
    .rst     (rst),
    .load_lo (wr_lo),
    .load_hi (wr_hi),
    .bit_in  (bus_wdata[0]),
    .sclk_q  (spi_sclk),
    .mosi_q  (spi_mosi)
  );

  spibb_miso_capture #(.STAGES(SYNC_STAGES)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .miso_pin (spi_miso),
    .capture  (wr_hi),
    .bit_q    (rx_bit)
  );

  spibb_ctrl_reg #(.CTRL_W(CTRL_W)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .we     (wr_ctrl),
    .wval   (bus_wdata[CTRL_W-1:0]),
    .ctrl_q (ctrl)
  );

  assign spi_cs_n = ctrl[0];
  assign spi_aux  = ctrl[CTRL_W-1:1];

  always_comb begin
    case (sel)
      REG_CLK_LO, REG_CLK_HI: rd_mux = {{(DATA_W-1){1'b0}}, rx_bit};
      REG_CTRL:               rd_mux = {{PAD_W{1'b0}}, ctrl};
      default:                rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
    else             bus_rdata <= '0;
  end
endmodule

// File: rtl/spibb_checker.sv
`timescale 1ns/1ps
module spibb_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              spi_sclk,
  input logic              spi_mosi,
  input logic              spi_cs_n
);
  AST_LOW_WRITE: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 2'd0) |=> (!spi_sclk && spi_mosi == $past(bus_wdata[0]))); // R2
  AST_HIGH_WRITE: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 2'd1) |=> (spi_sclk && spi_mosi == $past(bus_wdata[0]))); // R3
  AST_PINS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr[1] == 1'b0) |=> ($stable(spi_sclk) && $stable(spi_mosi))); // R4
  AST_CS_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 2'd2) |=> (spi_cs_n == $past(bus_wdata[0]))); // R5
  AST_DATA_READ_BIT0: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr[1] == 1'b0) |=> (bus_rdata[DATA_W-1:1] == '0)); // R6
  AST_PAD_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 2'd3) |=> $stable(spi_cs_n)); // R7
  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0)); // R8
endmodule

bind spi_bitbang_port spibb_checker #(.DATA_W(DATA_W)) u_spibb_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .spi_sclk  (spi_sclk),
  .spi_mosi  (spi_mosi),
  .spi_cs_n  (spi_cs_n)
);

// File: tb/tb_spi_bitbang_port.sv
`timescale 1ns/1ps
module tb_spi_bitbang_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        spi_sclk, spi_mosi, spi_cs_n;
  logic        spi_miso = 1'b0;
  logic [1:0]  spi_aux;

  int checks = 0;
  int failures = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [7:0]  mosi_seen = '0;
  logic [7:0]  rx_got = '0;

  always #2 clk = ~clk;

  spi_bitbang_port dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_cs_n(spi_cs_n), .spi_aux(spi_aux)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver tasks: inputs change on the falling edge.
  task automatic bus_write(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [1:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pins(string tag, logic sclk_e, logic mosi_e, logic cs_e);
    check({tag, " sclk"}, {31'd0, spi_sclk}, {31'd0, sclk_e});
    check({tag, " mosi"}, {31'd0, spi_mosi}, {31'd0, mosi_e});
    check({tag, " cs_n"}, {31'd0, spi_cs_n}, {31'd0, cs_e});
  endtask

  // Monitor: scoreboard compare one clock after each accepted read.
  initial begin
    forever begin
      logic was_rd;
      @(posedge clk);
      was_rd = bus_rd;
      #1;
      if (was_rd) begin
        if (exp_q.size() == 0) begin
          check("R8 unexpected read", 32'd1, 32'd0);
        end else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (t == "R9 rx") rx_got = {bus_rdata[0], rx_got[7:1]};
          check(t, bus_rdata, e);
        end
      end
    end
  end

  // Device model side: sample outgoing bit at each rising serial clock.
  always @(posedge spi_sclk) mosi_seen = {spi_mosi, mosi_seen[7:1]};

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] tx, rx;
    repeat (4) @(negedge clk);
    pins("R1 in reset", 1'b0, 1'b0, 1'b1);
    rst = 1'b0;
    @(negedge clk);
    pins("R1 after reset", 1'b0, 1'b0, 1'b1);
    check("R1 aux", {30'd0, spi_aux}, 32'd3);
    check("R1 rdata", bus_rdata, 32'd0);

    bus_write(2'd0, 32'hFFFF_FFFF); pins("R2 low write one", 1'b0, 1'b1, 1'b1);
    bus_write(2'd1, 32'hFFFF_FFFE); pins("R3 high write zero", 1'b1, 1'b0, 1'b1);
    bus_write(2'd1, 32'h0000_0003); pins("R3 high write one", 1'b1, 1'b1, 1'b1);
    bus_write(2'd0, 32'h0000_0002); pins("R2 upper bits ignored", 1'b0, 1'b0, 1'b1);

    bus_write(2'd1, 32'h1);
    repeat (5) @(negedge clk);
    bus_read(2'd2, 32'd7, "R5 ctrl reset readback");
    bus_write(2'd2, 32'h7);
    pins("R4 hold", 1'b1, 1'b1, 1'b1);

    bus_write(2'd2, 32'h0000_0002);
    check("R5 aux", {30'd0, spi_aux}, 32'd1);
    pins("R5 cs low", 1'b1, 1'b1, 1'b0);
    bus_read(2'd2, 32'd2, "R5 ctrl readback");
    bus_write(2'd2, 32'hFFFF_FFF9);
    check("R5 aux upper ignored", {30'd0, spi_aux}, 32'd0);
    bus_read(2'd2, 32'd1, "R5 ctrl zero-extend");

    bus_write(2'd3, 32'hFFFF_FFF0);
    pins("R7 pad write", 1'b1, 1'b1, 1'b1);
    check("R7 aux", {30'd0, spi_aux}, 32'd0);
    bus_read(2'd3, 32'd0, "R7 pad read");
    @(negedge clk);
    check("R8 idle rdata", bus_rdata, 32'd0);

    // R6 capture and synchronizer depth
    @(negedge clk); spi_miso = 1'b1;
    repeat (3) @(negedge clk);
    bus_write(2'd1, 32'h0);
    bus_read(2'd0, 32'd1, "R6 word0 capture");
    bus_read(2'd1, 32'd1, "R6 word1 capture");
    spi_miso = 1'b0;
    repeat (3) @(negedge clk);
    bus_write(2'd0, 32'h0);
    bus_read(2'd1, 32'd1, "R6 no capture on low write");
    bus_write(2'd1, 32'h0);
    bus_read(2'd0, 32'd0, "R6 capture zero");
    spi_miso = 1'b1;
    bus_write(2'd1, 32'h0);
    bus_read(2'd1, 32'd0, "R6 sync delay");
    bus_write(2'd1, 32'h0);
    bus_read(2'd1, 32'd1, "R6 after sync");

    // R9 full byte, least significant bit first
    bus_write(2'd0, 32'h0);
    bus_write(2'd2, 32'h6);
    mosi_seen = '0;
    tx = 8'hA5; rx = 8'h3C;
    begin
      logic [31:0] v;
      v = {24'd0, tx};
      for (int i = 0; i < 8; i++) begin
        spi_miso = rx[i];
        repeat (3) @(negedge clk);
        bus_write(2'd0, v);
        bus_write(2'd1, v);
        bus_read(2'd1, {31'd0, rx[i]}, "R9 rx");
        bus_write(2'd0, v);
        check("R9 clock low after bit", {31'd0, spi_sclk}, 32'd0);
        v = v >> 1;
      end
    end
    repeat (3) @(negedge clk);
    check("R9 mosi stream", {24'd0, mosi_seen}, {24'd0, tx});
    check("R9 rx assembled", {24'd0, rx_got}, {24'd0, rx});
    check("R9 cs held low", {31'd0, spi_cs_n}, 32'd0);
    check("R8 scoreboard drained", exp_q.size(), 32'd0);
    finish_run();
  end
endmodule